// File: doc/BRIEF.md
# Erase-Block Page Parity Accumulator

This block keeps a running bitwise XOR across the data pages of one flash erase block, so that the block behaves like a small RAID set whose members are pages. Words arrive on a write stream tagged with a page index and a word index. Each accepted word is folded into a parity buffer at the same word offset. The buffer stands in for a separate scratch memory that holds the parity while the block fills. When the last word of the final data page has been folded in, the block streams the buffer out, one word per cycle, as the contents of the block's last page. That page index is reserved for parity.

The same datapath regenerates a lost page. In rebuild mode the caller feeds the parity page and every surviving data page, in any order, through the write port. The stream that follows is the XOR of those pages, which is the missing page. Page and word counts are parameters. Data pages are written word by word in ascending word order, and a page counts as finished when its highest word index is written.

Top module: `page_parity_acc`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid`, `blk_done` and `wr_err` are low.
- R2: After PAGES-1 pages have been accepted, the output stream word at offset k equals the XOR of word k of every accepted page of that block.
- R3: The first accepted page of each block replaces the buffer contents, so nothing from an earlier block leaks into the next parity.
- R4: The first output word appears two cycles after the clock edge that accepts the final word. The stream then carries word indices 0 to WORDS-1 in ascending order, one per cycle, with `out_valid` high throughout.
- R5: `blk_done` is high for exactly one cycle, together with output word index 0, and never at any other time.
- R6: In normal mode (`rebuild` low), a write to page index PAGES-1 is rejected. `wr_err` is high on the next cycle, and neither the buffer nor the page count changes.
- R7: In rebuild mode (`rebuild` high), writes to page PAGES-1 are accepted. Feeding the parity page and all data pages but one produces the missing page on the output stream.
- R8: A write is rejected, with `wr_err` high on the next cycle and no effect on state, if it arrives in the cycle after the final word or while the output stream is running.
- R9: Idle cycles between accepted writes do not change the resulting parity or the timing rule of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rebuild | input | 1 | High selects page regeneration, low selects parity generation |
| wr_valid | input | 1 | A write word is present this cycle |
| wr_page | input | PW | Page index of the write |
| wr_word | input | WW | Word offset within the page |
| wr_data | input | DW | Write data |
| wr_err | output | 1 | The write of the previous cycle was rejected |
| out_valid | output | 1 | Output stream word is valid |
| out_word | output | WW | Word offset of the output word |
| out_data | output | DW | Parity or rebuilt word |
| blk_done | output | 1 | Block complete, marks the first output word |

## Verification
The bench runs two blocks back to back with different data. A design that failed to clear the buffer at the start of a block would output parity that still carries the previous block's words. It spaces writes with idle cycles and also writes word offsets back to back. Either case breaks a read-modify-write path that forwards or stalls wrongly, and the parity comes out corrupted. It aims writes at the reserved page index in the middle of a block and fires writes into the busy window right after completion. A design that let either one through would miscount pages, end the block early or late, or fold stray data into the parity. It then rebuilds a page from saved parity and compares the result with the original data. A design that rejected the parity index in rebuild mode would produce a wrong page.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  // index width that never collapses to zero bits
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ppa_ctrl.sv
module ppa_ctrl #(
  parameter int PAGES = 4,
  parameter int WORDS = 8,
  localparam int PW = ppa_pkg::idx_w(PAGES),
  localparam int WW = ppa_pkg::idx_w(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rebuild,
  input  logic          wr_valid,
  input  logic [PW-1:0] wr_page,
  input  logic [WW-1:0] wr_word,
  output logic          acc,
  output logic          first,
  output logic          wr_err,
  output logic          em_act,
  output logic [WW-1:0] em_idx,
  output logic          out_valid,
  output logic [WW-1:0] out_word,
  output logic          blk_done
);
  localparam int DPG = PAGES - 1;

  logic [PW-1:0] pg_cnt;
  logic          fin_pend;
  logic          reserved, busy, reject, last_word, fin;

  always_comb begin
    reserved  = !rebuild && (wr_page == PW'(PAGES - 1));
    busy      = em_act || fin_pend;
    reject    = wr_valid && (busy || reserved);
    acc       = wr_valid && !reject;
    last_word = (wr_word == WW'(WORDS - 1));
    first     = (pg_cnt == '0);
    fin       = acc && last_word && (pg_cnt == PW'(DPG - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_cnt    <= '0;
      fin_pend  <= 1'b0;
      em_act    <= 1'b0;
      em_idx    <= '0;
      wr_err    <= 1'b0;
      out_valid <= 1'b0;
      out_word  <= '0;
      blk_done  <= 1'b0;
    end else begin
      wr_err   <= reject;
      fin_pend <= fin;
      if (acc && last_word)
        pg_cnt <= fin ? '0 : pg_cnt + 1'b1;
      if (fin_pend) begin
        em_act <= 1'b1;
        em_idx <= '0;
      end else if (em_act) begin
        em_idx <= em_idx + 1'b1;
        if (em_idx == WW'(WORDS - 1))
          em_act <= 1'b0;
      end
      out_valid <= em_act;
      out_word  <= em_idx;
      blk_done  <= em_act && (em_idx == '0);
    end
  end
endmodule

// File: rtl/ppa_store.sv
module ppa_store #(
  parameter int WORDS = 8,
  parameter int DW    = 16,
  localparam int WW = ppa_pkg::idx_w(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          first,
  input  logic [WW-1:0] wr_word,
  input  logic [DW-1:0] wr_data,
  input  logic          em_act,
  input  logic [WW-1:0] em_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] rd_q;
  // stage 1: request captured while the old word is read
  logic          v1, f1;
  logic [WW-1:0] a1;
  logic [DW-1:0] d1;
  // stage 2 record: last word written, for forwarding
  logic          wv;
  logic [WW-1:0] wa;
  logic [DW-1:0] wd;
  logic [WW-1:0] raddr;
  logic [DW-1:0] old, nv;

  always_comb begin
    raddr = em_act ? em_idx : wr_word;
    old   = (wv && (wa == a1)) ? wd : rd_q;
    nv    = f1 ? d1 : (old ^ d1);
  end

  // plain dual-port memory, synchronous read
  always_ff @(posedge clk) begin
    if (v1)
      mem[a1] <= nv;
    rd_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      f1 <= 1'b0;
      a1 <= '0;
      d1 <= '0;
      wv <= 1'b0;
      wa <= '0;
      wd <= '0;
    end else begin
      v1 <= acc;
      f1 <= first;
      a1 <= wr_word;
      d1 <= wr_data;
      wv <= v1;
      wa <= a1;
      wd <= nv;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/page_parity_acc.sv
module page_parity_acc #(
  parameter int PAGES = 4,
  parameter int WORDS = 8,
  parameter int DW    = 16,
  localparam int PW = ppa_pkg::idx_w(PAGES),
  localparam int WW = ppa_pkg::idx_w(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rebuild,
  input  logic          wr_valid,
  input  logic [PW-1:0] wr_page,
  input  logic [WW-1:0] wr_word,
  input  logic [DW-1:0] wr_data,
  output logic          wr_err,
  output logic          out_valid,
  output logic [WW-1:0] out_word,
  output logic [DW-1:0] out_data,
  output logic          blk_done
);
  logic          acc, first, em_act;
  logic [WW-1:0] em_idx;

  ppa_ctrl #(.PAGES(PAGES), .WORDS(WORDS)) u_ctrl (
    .clk(clk), .rst(rst), .rebuild(rebuild), .wr_valid(wr_valid),
    .wr_page(wr_page), .wr_word(wr_word), .acc(acc), .first(first),
    .wr_err(wr_err), .em_act(em_act), .em_idx(em_idx),
    .out_valid(out_valid), .out_word(out_word), .blk_done(blk_done)
  );

  ppa_store #(.WORDS(WORDS), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .acc(acc), .first(first), .wr_word(wr_word),
    .wr_data(wr_data), .em_act(em_act), .em_idx(em_idx), .rd_data(out_data)
  );
endmodule

// File: rtl/ppa_checker.sv
module ppa_checker #(
  parameter int PAGES = 4,
  parameter int WORDS = 8,
  localparam int PW = ppa_pkg::idx_w(PAGES),
  localparam int WW = ppa_pkg::idx_w(WORDS)
) (
  input logic          clk,
  input logic          rst,
  input logic          rebuild,
  input logic          wr_valid,
  input logic [PW-1:0] wr_page,
  input logic          wr_err,
  input logic          out_valid,
  input logic [WW-1:0] out_word,
  input logic          blk_done
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> !out_valid && !wr_err && !blk_done);

  a_r6_reserved_flag: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !rebuild && (wr_page == PW'(PAGES - 1)) |=> wr_err);

  a_r6_err_needs_write: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(wr_valid));

  a_r5_done_word0: assert property (@(posedge clk) disable iff (rst)
    blk_done |-> out_valid && (out_word == '0));

  a_r5_done_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> blk_done);

  a_r4_word_step: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_word != WW'(WORDS - 1)) |=>
      out_valid && (out_word == $past(out_word) + 1'b1));

  a_r8_busy_reject: assert property (@(posedge clk) disable iff (rst)
    blk_done && wr_valid |=> wr_err);
endmodule

bind page_parity_acc ppa_checker #(.PAGES(PAGES), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst(rst), .rebuild(rebuild), .wr_valid(wr_valid),
  .wr_page(wr_page), .wr_err(wr_err), .out_valid(out_valid),
  .out_word(out_word), .blk_done(blk_done)
);

// File: tb/tb_page_parity_acc.sv
module tb_page_parity_acc;
  localparam int CLK_P = 10;
  localparam int PAGES = 4;
  localparam int WORDS = 8;
  localparam int DW    = 16;
  localparam int PW    = 2;
  localparam int WW    = 3;
  localparam int LAST  = PAGES - 1;

  logic          clk = 1'b0;
  logic          rst, rebuild, wr_valid;
  logic [PW-1:0] wr_page;
  logic [WW-1:0] wr_word;
  logic [DW-1:0] wr_data;
  logic          wr_err, out_valid, blk_done;
  logic [WW-1:0] out_word;
  logic [DW-1:0] out_data;

  page_parity_acc #(.PAGES(PAGES), .WORDS(WORDS), .DW(DW)) dut (
    .clk(clk), .rst(rst), .rebuild(rebuild), .wr_valid(wr_valid),
    .wr_page(wr_page), .wr_word(wr_word), .wr_data(wr_data),
    .wr_err(wr_err), .out_valid(out_valid), .out_word(out_word),
    .out_data(out_data), .blk_done(blk_done)
  );

  always #(CLK_P/2) clk = ~clk;

  int    vectors = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    finished = 0;
  string cur_req = "R1";

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { int due; int word; logic [DW-1:0] data; } exp_t;
  exp_t          q[$];
  int            m_pg = 0;
  int            m_busy_end = -1;
  logic [DW-1:0] par [WORDS];
  logic [DW-1:0] lastpar [WORDS];
  logic          e_v = 0, e_err = 0, e_done = 0;
  int            e_w = 0;
  logic [DW-1:0] e_d = '0;
  bit            rej;

  always @(posedge clk) begin
    cyc++;
    e_v = 0; e_done = 0; e_err = 0;
    if (rst) begin
      m_pg = 0; m_busy_end = -1; q.delete();
    end else begin
      rej = wr_valid && ((cyc <= m_busy_end) || (!rebuild && int'(wr_page) == LAST));
      e_err = rej;
      if (wr_valid && !rej) begin
        if (m_pg == 0) par[int'(wr_word)] = wr_data;
        else           par[int'(wr_word)] = par[int'(wr_word)] ^ wr_data;
        if (int'(wr_word) == WORDS - 1) begin
          if (m_pg == PAGES - 2) begin
            for (int i = 0; i < WORDS; i++) begin
              exp_t e;
              e.due = cyc + 2 + i; e.word = i; e.data = par[i];
              q.push_back(e);
              lastpar[i] = par[i];
            end
            m_pg = 0;
            m_busy_end = cyc + 1 + WORDS;
          end else begin
            m_pg++;
          end
        end
      end
      if (q.size() > 0 && q[0].due == cyc) begin
        e_v = 1; e_w = q[0].word; e_d = q[0].data; e_done = (q[0].word == 0);
        void'(q.pop_front());
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  logic [DW-1:0] lost [WORDS];
  bit            rb_chk = 0;

  always @(negedge clk) begin
    if (!rst && cyc > 0 && !finished) begin
      check(cur_req, "out_valid", 32'(out_valid), 32'(e_v));
      check(cur_req, "blk_done", 32'(blk_done), 32'(e_done));
      check(cur_req, "wr_err", 32'(wr_err), 32'(e_err));
      if (e_v) begin
        check(cur_req, "out_word", 32'(out_word), 32'(e_w));
        check(cur_req, "out_data", 32'(out_data), 32'(e_d));
      end
      if (rb_chk && out_valid)
        check("R7", "rebuilt word", 32'(out_data), 32'(lost[int'(out_word)]));
    end
  end

  // ---------------- stimulus ----------------
  logic [DW-1:0] pgdat [PAGES][WORDS];

  task automatic put(input int p, input int w, input logic [DW-1:0] d);
    wr_valid = 1'b1; wr_page = PW'(p); wr_word = WW'(w); wr_data = d;
    pgdat[p][w] = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic page(input int p, input int gap);
    for (int w = 0; w < WORDS; w++) begin
      put(p, w, DW'($urandom));
      idle(gap);
    end
  endtask

  task automatic block(input int gap);
    for (int p = 0; p < PAGES - 1; p++) page(p, gap);
    idle(WORDS + 4);
  endtask

  logic [DW-1:0] s0 [WORDS];
  logic [DW-1:0] s2 [WORDS];
  logic [DW-1:0] sp [WORDS];

  initial begin
    rst = 1'b1; rebuild = 1'b0; wr_valid = 1'b0;
    wr_page = '0; wr_word = '0; wr_data = '0;
    idle(3);
    check("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    check("R1", "blk_done in reset", 32'(blk_done), 32'd0);
    check("R1", "wr_err in reset", 32'(wr_err), 32'd0);
    rst = 1'b0;
    idle(1);
    check("R1", "out_valid after reset", 32'(out_valid), 32'd0);

    cur_req = "R2,R4,R5";
    block(0);

    cur_req = "R3,R9";
    page(0, 2); page(1, 1); page(2, 3);
    idle(WORDS + 4);
    block(0);

    cur_req = "R6";
    page(0, 0);
    put(LAST, 0, 16'hdead);
    put(LAST, 5, 16'hbeef);
    page(1, 0);
    put(LAST, WORDS - 1, 16'h1234);
    page(2, 0);
    idle(WORDS + 4);

    cur_req = "R8";
    page(0, 0); page(1, 0); page(2, 0);
    put(0, 0, 16'h5a5a);
    idle(2);
    put(1, WORDS - 1, 16'ha5a5);
    put(0, 1, 16'h0f0f);
    idle(WORDS + 4);
    block(0);

    cur_req = "R7";
    block(1);
    for (int w = 0; w < WORDS; w++) begin
      lost[w] = pgdat[1][w]; s0[w] = pgdat[0][w];
      s2[w] = pgdat[2][w]; sp[w] = lastpar[w];
    end
    rebuild = 1'b1;
    rb_chk = 1;
    for (int w = 0; w < WORDS; w++) put(LAST, w, sp[w]);
    for (int w = 0; w < WORDS; w++) put(2, w, s2[w]);
    for (int w = 0; w < WORDS; w++) put(0, w, s0[w]);
    idle(WORDS + 4);
    rb_chk = 0;
    rebuild = 1'b0;

    cur_req = "R2,R3";
    block(0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule